// File: doc/BRIEF.md
# CAN Bit Timing Resynchronizer

This block sets the bit timing of a CAN receiver. Every bit is cut into equal time quanta, paced by a one-cycle quantum enable `tq_en`. A bit starts with one sync quantum. After it comes a first timing segment, which is the propagation quanta (`prop_len`) followed by the first phase quanta (`ph1_len`). A second phase segment closes the bit. Its length always equals the jump width `sjw_len`. The receive line is sampled at the boundary between the two phase segments. The sampled value is returned with a one-cycle strobe.

Only recessive-to-dominant transitions on `rx` count as edges, and `rx` is looked at only on quantum ticks. While the bus is idle, an edge hard-synchronizes the receiver: the quantum that held the edge becomes the sync quantum of a new bit. Inside a frame, an edge moves the bit phase. A late edge, seen in the first timing segment, lengthens that segment by its phase error, clamped to the jump width. An early edge, seen in the second phase segment, ends the bit at once. Because of these corrections the receiver follows a transmitter whose clock runs slightly fast or slow. Destuffing, framing, error handling and CRC are left to the logic that follows.

Top module: `can_bit_resync`

## Requirements
- R1: With no edge, `bit_start` pulses are 1+`prop_len`+`ph1_len`+`sjw_len` quantum ticks apart. `sample_stb` follows a `bit_start` by `prop_len`+`ph1_len` ticks, and it precedes the next `bit_start` by `sjw_len`+1 ticks.
- R2: `rx` uses 1 for recessive and 0 for dominant. At each `sample_stb`, `sample_bit` holds the value `rx` had at the tick that caused the strobe.
- R3: A hard sync is caused by an edge seen at a tick while idle. It makes that tick raise `bit_start`, wherever the bit counter stood. The next sample then comes `prop_len`+`ph1_len` ticks later.
- R4: The receiver is idle after reset and after 11 consecutive recessive samples. A dominant sample or a hard sync clears idle. An edge seen while not idle never causes a hard sync.
- R5: Let an edge be seen n ticks after a `bit_start`, inside the first timing segment. The sample then comes `prop_len`+`ph1_len`+min(n, `sjw_len`) ticks after that `bit_start`.
- R6: An edge seen in the second phase segment raises `bit_start` at that same tick.
- R7: Between two samples at most one resynchronization is applied, and a hard sync counts as one. A further edge in that interval changes nothing.
- R8: A dominant-to-recessive transition never moves the bit phase.
- R9: The transmitter may run 1% fast or slow with 10 quanta per bit, or 0.6% with 8 quanta per bit. Runs of 10 bits with no edge are sampled correctly, and so is the 13th bit after the last edge. The n-th sample after a hard sync equals the n-th bit sent.
- R10: After reset `sample_stb` and `bit_start` are 0 and `sample_bit` is 1. Both strobes are one-cycle pulses, each in the cycle right after a quantum tick, and they never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_en | input | 1 | One-cycle pulse marking the end of a time quantum |
| rx | input | 1 | Receive line, already synchronized; 1 is recessive |
| prop_len | input | SEG_W | Propagation quanta, with prop_len+ph1_len at least 1 |
| ph1_len | input | SEG_W | First phase segment quanta |
| sjw_len | input | SEG_W | Jump width and second phase segment quanta, at least 1 |
| sample_stb | output | 1 | Pulse at the sample point |
| sample_bit | output | 1 | Value sampled at the last sample point |
| bit_start | output | 1 | Pulse at the end of the sync quantum of each bit |

## Verification
Directed steps put a single falling edge at chosen quantum offsets. These cover a late edge inside the clamp and one beyond it, an early edge in the second phase segment, a second edge after a correction, a rising transition, and an edge with 10 against 11 recessive samples before it. Each one moves the sample or bit-start tick in its own way, so wrong clamping, a missing hard sync or a double correction shows up as a tick count that is off. Random bit-stuffed frames from a transmitter that is nominal, fast or slow, in both timing setups, check that the stream of sampled bits matches the stream sent. Fixed frames with a 10-bit and a 13-bit stretch with no edge, at the fast and slow extremes, show whether phase drift is corrected often enough.

// File: rtl/can_bit_resync.sv
module can_bit_resync #(
  parameter int SEG_W     = 4,
  parameter int IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);

  localparam int CNT_W  = SEG_W + 2;
  localparam int IDLE_W = $clog2(IDLE_BITS + 1);

  typedef enum logic [1:0] {S_SYNC, S_T1, S_T2} seg_t;

  seg_t              seg;
  logic [CNT_W-1:0]  cnt, t1lim;
  logic              prev_rx, done, idle;
  logic [IDLE_W-1:0] rcnt;

  wire              fall    = tq_en & prev_rx & ~rx;
  wire              hard    = fall & idle;
  wire              soft_ok = fall & ~idle & ~done;
  wire              late    = soft_ok & (seg == S_T1);
  wire              early   = soft_ok & (seg == S_T2);
  wire [CNT_W-1:0]  base    = CNT_W'(prop_len) + CNT_W'(ph1_len);
  wire [CNT_W-1:0]  sjw_x   = CNT_W'(sjw_len);
  wire [CNT_W-1:0]  err     = cnt + 1'b1;
  wire [CNT_W-1:0]  adj     = (err < sjw_x) ? err : sjw_x;
  wire [CNT_W-1:0]  lim_n   = late ? t1lim + adj : t1lim;
  wire              t1_end  = (seg == S_T1) && (cnt == lim_n - 1'b1);
  wire              t2_end  = (seg == S_T2) && (cnt == sjw_x - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg        <= S_SYNC;
      cnt        <= '0;
      t1lim      <= '0;
      prev_rx    <= 1'b1;
      done       <= 1'b0;
      idle       <= 1'b1;
      rcnt       <= '0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_start  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      if (tq_en) begin
        prev_rx <= rx;
        if (hard) begin
          seg       <= S_T1;
          cnt       <= '0;
          t1lim     <= base;
          done      <= 1'b1;
          idle      <= 1'b0;
          rcnt      <= '0;
          bit_start <= 1'b1;
        end else begin
          case (seg)
            S_SYNC: begin
              seg       <= S_T1;
              cnt       <= '0;
              t1lim     <= base;
              bit_start <= 1'b1;
            end
            S_T1: begin
              t1lim <= lim_n;
              if (late) done <= 1'b1;
              if (t1_end) begin
                seg        <= S_T2;
                cnt        <= '0;
                done       <= 1'b0;
                sample_stb <= 1'b1;
                sample_bit <= rx;
                if (rx) begin
                  if (rcnt == IDLE_W'(IDLE_BITS - 1)) idle <= 1'b1;
                  else rcnt <= rcnt + 1'b1;
                end else begin
                  rcnt <= '0;
                  idle <= 1'b0;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_T2: begin
              if (early) begin
                seg       <= S_T1;
                cnt       <= '0;
                t1lim     <= base;
                done      <= 1'b1;
                bit_start <= 1'b1;
              end else if (t2_end) begin
                seg <= S_SYNC;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: seg <= S_SYNC;
          endcase
        end
      end
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start));

  a_r10_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || bit_start) |-> $past(tq_en));

  a_r2_sample_value: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sample_bit == $past(rx)));

  a_r4_hard_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && $past(seg) == S_T1) |-> $past(idle));

  a_r6_early_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && $past(seg) == S_T2) |-> ($past(prev_rx) && !$past(rx)));

  a_r7_once_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && $past(seg) == S_T2) |-> !$past(done));

endmodule

// File: tb/tb_can_bit_resync.sv
module tb_can_bit_resync;
  localparam int P = 20;

  logic       clk = 1'b0, rst_n = 1'b0, tq_en = 1'b0, rx = 1'b1;
  logic [3:0] prop_len = 4'd3, ph1_len = 4'd3, sjw_len = 4'd3;
  logic       sample_stb, sample_bit, bit_start;

  always #2 clk = ~clk;

  can_bit_resync #(.SEG_W(4), .IDLE_BITS(11)) dut (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx(rx),
    .prop_len(prop_len), .ph1_len(ph1_len), .sjw_len(sjw_len),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_start(bit_start));

  int total = 0, bad = 0, cyc = 0, tk = 0, bs_tk = 0, ss_tk = 0, n_ss = 0;
  int cap_k = 0, flen = 0, fstart = 0, ftb = 100;
  bit fon = 0, cap_on = 0, saw_bs = 0, saw_ss = 0, man_rx = 1;
  bit fb [0:79];

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (sample_stb || bit_start)
      check(!(sample_stb && bit_start), "R10 strobes together", 1, 0);
    if (bit_start) begin
      bs_tk = tk; saw_bs = 1;
      if (fon && !cap_on && cyc >= fstart) begin cap_on = 1; cap_k = 0; end
    end
    if (sample_stb) begin
      ss_tk = tk; saw_ss = 1; n_ss++;
      if (cap_on && cap_k < flen) begin
        check(sample_bit == fb[cap_k], "R9 sampled stream", int'(sample_bit), int'(fb[cap_k]));
        cap_k++;
      end
    end
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    tq_en = rst_n && (cyc % P == 0);
    if (tq_en) tk++;
    if (fon) begin
      if (cyc < fstart) rx = 1'b1;
      else if ((cyc - fstart) / ftb < flen) rx = fb[(cyc - fstart) / ftb];
      else rx = 1'b1;
    end else begin
      rx = man_rx;
    end
  endtask

  task automatic wait_bs();
    saw_bs = 0;
    do step(); while (!saw_bs);
  endtask

  task automatic wait_ss();
    saw_ss = 0;
    do step(); while (!saw_ss);
  endtask

  task automatic step_to(int t);
    while (tk < t) step();
  endtask

  task automatic go_idle();
    man_rx = 1;
    repeat (12) wait_ss();
  endtask

  task automatic run_frame(int tb_len);
    int nom;
    nom = (1 + int'(prop_len) + int'(ph1_len) + int'(sjw_len)) * P;
    ftb = tb_len;
    fstart = cyc + 5 + $urandom_range(0, P);
    cap_on = 0; cap_k = 0; fon = 1;
    while (cyc < fstart + flen * ftb + 2 * nom) step();
    fon = 0; man_rx = 1;
    check(cap_k == flen, "R9 bits captured", cap_k, flen);
    cap_on = 0;
    go_idle();
  endtask

  initial begin
    int b, s, h, last, run;
    void'($urandom(32'h5eed_1234));
    repeat (5) step();
    rst_n = 1;
    step();
    check(sample_stb == 0, "R10 reset sample_stb", int'(sample_stb), 0);
    check(bit_start == 0, "R10 reset bit_start", int'(bit_start), 0);
    check(sample_bit == 1, "R10 reset sample_bit", int'(sample_bit), 1);

    // R3: hard sync from idle after reset
    step_to(7); man_rx = 0;
    wait_bs();
    check(bs_tk == 8, "R3 hard sync tick", bs_tk, 8);
    h = bs_tk;
    // R7: second edge after hard sync ignored
    man_rx = 1; step_to(h + 2); man_rx = 0;
    wait_ss();
    check(ss_tk == h + 6, "R7 ignore after hard sync", ss_tk - h, 6);
    check(sample_bit == 0, "R2 dominant sample", int'(sample_bit), 0);
    s = ss_tk;
    man_rx = 1;
    wait_bs();
    check(bs_tk - s == 4, "R1 sample to bit start", bs_tk - s, 4);
    check(bs_tk - h == 10, "R1 bit length", bs_tk - h, 10);

    // R5: late edge n=2 within jump width
    b = bs_tk; step_to(b + 1); man_rx = 0;
    wait_ss();
    check(ss_tk - b == 8, "R5 late edge n=2", ss_tk - b, 8);
    s = ss_tk; man_rx = 1;
    wait_bs();
    check(bs_tk - s == 4, "R1 phase2 after lengthening", bs_tk - s, 4);
    // R5: late edge n=5 clamped to 3
    b = bs_tk; step_to(b + 4); man_rx = 0;
    wait_ss();
    check(ss_tk - b == 9, "R5 late edge clamped", ss_tk - b, 9);

    // R8: rising transition in segment 1 moves nothing
    wait_bs();
    b = bs_tk; step_to(b + 2); man_rx = 1;
    wait_ss();
    check(ss_tk - b == 6, "R8 rising edge ignored", ss_tk - b, 6);
    check(sample_bit == 1, "R2 recessive sample", int'(sample_bit), 1);

    // R6: early edge in phase segment 2
    s = ss_tk; step_to(s + 1); man_rx = 0;
    wait_bs();
    check(bs_tk == s + 2, "R6 early edge restarts bit", bs_tk - s, 2);
    // R7: a second edge in the same bit is ignored
    b = bs_tk; man_rx = 1; step_to(b + 2); man_rx = 0;
    wait_ss();
    check(ss_tk - b == 6, "R7 one correction per bit", ss_tk - b, 6);

    // R4: 10 recessive samples are not idle
    man_rx = 1;
    repeat (10) wait_ss();
    wait_bs();
    b = bs_tk; step_to(b + 4); man_rx = 0;
    wait_ss();
    check(ss_tk - b == 9, "R4 not idle after 10", ss_tk - b, 9);
    // R4: 11 recessive samples give idle, edge hard-syncs
    man_rx = 1;
    repeat (11) wait_ss();
    wait_bs();
    b = bs_tk; step_to(b + 4); man_rx = 0;
    wait_bs();
    check(bs_tk - b == 5, "R4 hard sync after 11", bs_tk - b, 5);
    h = bs_tk;
    wait_ss();
    check(ss_tk - h == 6, "R3 sample after hard sync", ss_tk - h, 6);
    go_idle();

    // R9: fixed frames, 10-bit and 13-bit stretches without edge
    for (int v = 0; v < 4; v++) begin
      if (v < 2) begin
        flen = 14;
        fb[0] = 0; fb[1] = 1;
        for (int i = 2; i < 7; i++) fb[i] = 0;
        for (int i = 7; i < 12; i++) fb[i] = 1;
        fb[12] = 0; fb[13] = 1;
      end else begin
        flen = 16;
        fb[0] = 0; fb[1] = 1;
        for (int i = 2; i < 9; i++) fb[i] = 0;
        for (int i = 9; i < 16; i++) fb[i] = 1;
      end
      run_frame((v % 2 == 0) ? 10 * P - 2 : 10 * P + 2);
    end

    // R9: random stuffed frames, two timing setups, random drift
    for (int f = 0; f < 8; f++) begin
      int nom, d;
      if ($urandom_range(0, 1) == 0) begin
        prop_len = 3; ph1_len = 3; sjw_len = 3; d = $urandom_range(0, 4) - 2;
      end else begin
        prop_len = 2; ph1_len = 3; sjw_len = 2; d = $urandom_range(0, 2) - 1;
      end
      nom = (1 + int'(prop_len) + int'(ph1_len) + int'(sjw_len)) * P;
      flen = $urandom_range(20, 30);
      fb[0] = 0; last = 0; run = 1;
      for (int i = 1; i < flen; i++) begin
        int bv;
        bv = (run == 5) ? 1 - last : int'($urandom_range(0, 1));
        run = (bv == last) ? run + 1 : 1;
        last = bv;
        fb[i] = bv[0];
      end
      go_idle();
      run_frame(nom + d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule